// File: doc/BRIEF.md
# Half-Duplex Serial Character Receiver

This block is the receive half of a half-duplex serial physical layer. It takes characters from a single data line that is timed by an external serial clock. That clock reaches the block as two strobes, each one system-clock cycle wide and synchronous to the system clock: one marks a rising serial-clock edge and the other a falling one. The line is sampled only on rising strobes. A character is one low start bit, eight data bits sent least significant bit first, one even-parity bit and two stop bits, which makes twelve bit times in all. The block checks each character and delivers the good ones as a byte on a valid/ready output. It reports parity errors, framing errors and the BREAK character on plain one-cycle flags.

An enable input selects receive mode. While the enable is low, the surrounding layer is transmitting. In that mode the receiver holds itself idle and reports nothing, so a BREAK that arrives then is never flagged as a break. After any error or break, the receiver waits until it has sampled the line high before it looks for the next start bit. Results appear on the system-clock cycle after the falling strobe that follows the final stop-bit sample.

The byte output has no back-pressure toward the serial line, because the line cannot be paused. `rx_valid` stays high with `rx_data` stable until the consumer raises `rx_ready`. A newer good byte that completes before the consumer accepts the current one replaces it.

Top module: `hdx_frame_rx`

## Requirements
- R1: After reset `rx_valid`, `par_err`, `frm_err` and `brk_det` are all low, and the receiver is hunting for a start bit.
- R2: The line is sampled only in system-clock cycles where `sclk_rise` is high. Line activity together with `sclk_fall` alone, or between strobes, has no effect.
- R3: A low sample while hunting starts a character. The next eight samples are data bits, least significant bit first, followed by one parity bit and two stop bits. A character with correct parity and both stops high is delivered once on `rx_data`.
- R4: Parity is even: the eight data bits plus the parity bit must hold an even number of ones. A mismatch raises `par_err` and the byte is not delivered.
- R5: If either stop bit is sampled low, `frm_err` is raised and the byte is not delivered. `par_err` and `frm_err` may be raised together.
- R6: Twelve consecutive low samples, from the start position through both stop positions, raise `brk_det` only. Neither `par_err` nor `frm_err` is raised and no byte is delivered.
- R7: While `rx_en` is low, the receiver drops any partial character and reports nothing. A BREAK on the line therefore yields no `brk_det`. Once `rx_en` is high again, the receiver needs a high sample before it hunts.
- R8: After a character that ends in an error or a break, low samples are ignored until one high sample has been taken.
- R9: The outcome of a character appears on the cycle after the first `sclk_fall` that follows its last stop-bit sample, not earlier. `par_err`, `frm_err` and `brk_det` are high for exactly one cycle.
- R10: `rx_valid` stays high with `rx_data` unchanged until a cycle with `rx_ready` high. A newer good byte that completes before acceptance overwrites `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_rise | input | 1 | One-cycle strobe at each rising serial-clock edge |
| sclk_fall | input | 1 | One-cycle strobe at each falling serial-clock edge |
| line_in | input | 1 | Sampled serial data line |
| rx_en | input | 1 | High selects receive mode |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte available |
| rx_ready | input | 1 | Consumer accepts the byte |
| par_err | output | 1 | One-cycle parity-error flag |
| frm_err | output | 1 | One-cycle framing-error flag |
| brk_det | output | 1 | One-cycle break flag |

## Verification
A wrong bit count or a wrong shift order inside the receiver shows within one character time: the delivered byte comes out rotated or shifted, or a good character is flagged with a parity or framing error. If the receiver fails to wait for a high sample after an error or break, it resynchronises on a low data bit, and the following good character is then lost or corrupted at the next delivery. Holding state has an effect only when the consumer stalls. There, a lost or altered byte shows on `rx_data` while `rx_valid` is still high.

// File: rtl/hdx_rx_pkg.sv
package hdx_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_BODY  = 2'd1,
    ST_JUDGE = 2'd2,
    ST_HOLD  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/hdx_rx_shift.sv
module hdx_rx_shift
  import hdx_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk_rise,
  input  logic                          line_in,
  input  logic                          rx_en,
  input  logic                          clean,
  output logic [DATA_W+STOP_W:0]        body,
  output logic                          all_low,
  output logic                          done
);
  localparam int BODY_W = DATA_W + 1 + STOP_W;
  localparam int CNT_W  = $clog2(BODY_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BODY_W - 1);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;

  assign done = (st == ST_JUDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      body    <= '0;
      all_low <= 1'b0;
    end else if (!rx_en) begin
      st  <= ST_HOLD;
      cnt <= '0;
    end else begin
      case (st)
        ST_HUNT: if (sclk_rise && !line_in) begin
          st      <= ST_BODY;
          cnt     <= '0;
          all_low <= 1'b1;
        end
        ST_BODY: if (sclk_rise) begin
          body    <= {line_in, body[BODY_W-1:1]};
          all_low <= all_low & ~line_in;
          cnt     <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_JUDGE;
        end
        ST_JUDGE: st <= clean ? ST_HUNT : ST_HOLD;
        ST_HOLD: if (sclk_rise && line_in) st <= ST_HUNT;
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/hdx_rx_judge.sv
module hdx_rx_judge #(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2
) (
  input  logic [DATA_W+STOP_W:0] body,
  input  logic                   all_low,
  output logic [DATA_W-1:0]      data,
  output logic                   brk,
  output logic                   pe,
  output logic                   fe,
  output logic                   clean
);
  localparam int BODY_W = DATA_W + 1 + STOP_W;

  logic [STOP_W-1:0] stops;
  logic              odd;

  always_comb begin
    data  = body[DATA_W-1:0];
    stops = body[BODY_W-1:DATA_W+1];
    odd   = ^body[DATA_W:0];
    brk   = all_low;
    pe    = !all_low && odd;
    fe    = !all_low && !(&stops);
    clean = !brk && !pe && !fe;
  end
endmodule

// File: rtl/hdx_rx_pub.sv
module hdx_rx_pub #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              brk,
  input  logic              pe,
  input  logic              fe,
  input  logic              clean,
  input  logic              sclk_fall,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_det
);
  logic              pend, p_good, p_pe, p_fe, p_brk;
  logic [DATA_W-1:0] p_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; p_good <= 1'b0; p_pe <= 1'b0; p_fe <= 1'b0; p_brk <= 1'b0;
      p_data <= '0;
    end else if (done) begin
      pend <= 1'b1; p_good <= clean; p_pe <= pe; p_fe <= fe; p_brk <= brk;
      p_data <= data;
    end else if (sclk_fall) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      brk_det  <= 1'b0;
    end else begin
      par_err <= 1'b0;
      frm_err <= 1'b0;
      brk_det <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (pend && sclk_fall && !done) begin
        par_err <= p_pe;
        frm_err <= p_fe;
        brk_det <= p_brk;
        if (p_good) begin
          rx_data  <= p_data;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdx_frame_rx.sv
module hdx_frame_rx #(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              line_in,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_det
);
  localparam int BODY_W = DATA_W + 1 + STOP_W;

  logic [BODY_W-1:0] body;
  logic              all_low, done, clean, brk, pe, fe;
  logic [DATA_W-1:0] data;

  hdx_rx_shift #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .line_in(line_in),
    .rx_en(rx_en), .clean(clean), .body(body), .all_low(all_low), .done(done)
  );

  hdx_rx_judge #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_judge (
    .body(body), .all_low(all_low), .data(data), .brk(brk), .pe(pe),
    .fe(fe), .clean(clean)
  );

  hdx_rx_pub #(.DATA_W(DATA_W)) u_pub (
    .clk(clk), .rst_n(rst_n), .done(done), .data(data), .brk(brk), .pe(pe),
    .fe(fe), .clean(clean), .sclk_fall(sclk_fall), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .brk_det(brk_det)
  );
endmodule

// File: rtl/hdx_frame_rx_chk.sv
module hdx_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_fall,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              par_err,
  input logic              frm_err,
  input logic              brk_det
);
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid) else $error("hold"); // R10
  AST_BRK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> !par_err && !frm_err) else $error("brk alone"); // R6
  AST_FLAG_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err || frm_err || brk_det) |-> $past(sclk_fall)) else $error("fall"); // R9
  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err || frm_err || brk_det) |=> !par_err && !frm_err && !brk_det) else $error("pulse"); // R9
  AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(sclk_fall)) else $error("valid fall"); // R9
endmodule

bind hdx_frame_rx hdx_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .par_err(par_err),
  .frm_err(frm_err), .brk_det(brk_det)
);

// File: tb/sim_hdx_frame_rx.sv
module sim_hdx_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rise = 1'b0, fall = 1'b0, sdata = 1'b1, rx_en = 1'b1, ready = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, par_err, frm_err, brk_det;
  int checks = 0, fails = 0;
  int n_byte = 0, n_pe = 0, n_fe = 0, n_brk = 0;
  logic [7:0] last_byte = 8'h00;

  always #10 clk = ~clk;

  hdx_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .sclk_rise(rise), .sclk_fall(fall),
    .line_in(sdata), .rx_en(rx_en), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(ready), .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det)
  );

  always @(negedge clk) begin
    if (rx_valid && ready) begin n_byte++; last_byte = rx_data; end
    if (par_err) n_pe++;
    if (frm_err) n_fe++;
    if (brk_det) n_brk++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_byte = 0; n_pe = 0; n_fe = 0; n_brk = 0;
  endtask

  task automatic bit_rise(input logic v);
    @(negedge clk); sdata = v; rise = 1'b1;
    @(negedge clk); rise = 1'b0;
    @(negedge clk);
  endtask

  task automatic bit_fall();
    fall = 1'b1; @(negedge clk); fall = 1'b0; @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    bit_rise(v); bit_fall();
  endtask

  // frame body up to and including the first stop bit
  task automatic send_head(input logic [7:0] d, input logic flip, input logic s1);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((^d) ^ flip);
    send_bit(s1);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip,
                            input logic s1, input logic s2);
    send_head(d, flip, s1);
    send_bit(s2);
  endtask

  function automatic int exp_pe(input logic flip); return flip ? 1 : 0; endfunction
  function automatic int exp_fe(input logic s1, input logic s2);
    return (s1 && s2) ? 0 : 1;
  endfunction
  function automatic int exp_nb(input logic flip, input logic s1, input logic s2);
    return (!flip && s1 && s2) ? 1 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(rx_valid), 0);
    check("R1 flags", int'(par_err | frm_err | brk_det), 0);

    // R3 directed good frame
    clr(); send_frame(8'hA1, 1'b0, 1'b1, 1'b1); send_bit(1'b1);
    check("R3 count", n_byte, 1);
    check("R3 byte", int'(last_byte), 8'hA1);

    // R2 fall-only activity with low line is ignored
    clr();
    repeat (4) begin @(negedge clk); sdata = 1'b0; bit_fall(); end
    sdata = 1'b1; repeat (3) @(negedge clk);
    check("R2 no output", n_byte + n_pe + n_fe + n_brk, 0);
    send_frame(8'h5E, 1'b0, 1'b1, 1'b1); send_bit(1'b1);
    check("R2 next byte", int'(last_byte), 8'h5E);
    check("R2 count", n_byte, 1);

    // R4 parity, R5 both stops / first stop
    clr(); send_frame(8'h00, 1'b1, 1'b1, 1'b1); send_bit(1'b1);
    check("R4 pe", n_pe, 1); check("R4 no byte", n_byte, 0);
    clr(); send_frame(8'hFF, 1'b0, 1'b0, 1'b1); send_bit(1'b1);
    check("R5 fe", n_fe, 1); check("R5 no byte", n_byte + n_pe, 0);
    clr(); send_frame(8'h81, 1'b1, 1'b1, 1'b0); send_bit(1'b1);
    check("R5 both pe", n_pe, 1); check("R5 both fe", n_fe, 1);

    // R6 break
    clr(); repeat (12) send_bit(1'b0); send_bit(1'b1);
    check("R6 brk", n_brk, 1);
    check("R6 no errs", n_pe + n_fe + n_byte, 0);

    // R8 low samples after break ignored until a high sample
    clr(); repeat (12) send_bit(1'b0); repeat (5) send_bit(1'b0);
    send_bit(1'b1); send_frame(8'hA5, 1'b0, 1'b1, 1'b1); send_bit(1'b1);
    check("R8 brk", n_brk, 1);
    check("R8 byte count", n_byte, 1);
    check("R8 byte", int'(last_byte), 8'hA5);
    check("R8 no errs", n_pe + n_fe, 0);

    // R7 break while not in receive mode
    clr(); rx_en = 1'b0; repeat (12) send_bit(1'b0); send_bit(1'b1);
    check("R7 no brk", n_brk + n_pe + n_fe + n_byte, 0);
    rx_en = 1'b1; send_bit(1'b1);
    // R7 partial frame dropped when rx_en falls
    clr(); send_bit(1'b0); repeat (4) send_bit(1'b1);
    rx_en = 1'b0; send_bit(1'b1); rx_en = 1'b1; send_bit(1'b1);
    send_frame(8'h3D, 1'b0, 1'b1, 1'b1); send_bit(1'b1);
    check("R7 count", n_byte, 1);
    check("R7 byte", int'(last_byte), 8'h3D);
    check("R7 no errs", n_pe + n_fe + n_brk, 0);

    // R9 timing and R10 hold/overwrite
    clr(); ready = 1'b0;
    send_head(8'h3C, 1'b0, 1'b1); bit_rise(1'b1);
    repeat (2) @(negedge clk);
    check("R9 not before fall", int'(rx_valid), 0);
    bit_fall();
    check("R9 after fall", int'(rx_valid), 1);
    check("R10 data", int'(rx_data), 8'h3C);
    send_bit(1'b1); repeat (3) @(negedge clk);
    check("R10 held", int'(rx_valid), 1);
    check("R10 held data", int'(rx_data), 8'h3C);
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1); send_bit(1'b1);
    check("R10 overwrite", int'(rx_data), 8'hC3);
    ready = 1'b1; repeat (2) @(negedge clk);
    check("R10 drained", int'(rx_valid), 0);
    check("R10 one byte taken", n_byte, 1);

    // R3 R4 R5 random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic flip, s1, s2;
      int mode;
      d = 8'($urandom);
      mode = int'($urandom % 4);
      flip = (mode == 2);
      s1 = !(mode == 3 && $urandom % 2 == 0);
      s2 = !(mode == 3) || !s1 ? 1'b1 : 1'b0;
      if (mode == 3 && s1) s2 = 1'b0;
      clr(); send_frame(d, flip, s1, s2); send_bit(1'b1);
      check("R3 rand count", n_byte, exp_nb(flip, s1, s2));
      if (exp_nb(flip, s1, s2) == 1) check("R3 rand byte", int'(last_byte), int'(d));
      check("R4 rand pe", n_pe, exp_pe(flip));
      check("R5 rand fe", n_fe, exp_fe(s1, s2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule